// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter

This block sits on a simple processor bus and gives the processor two 8-bit general-purpose ports, A and B. A direction register sets each pin of a port to input or output. The processor reaches the direction register, the data register and the control register of each port through a 2-bit register offset. The direction register and the data register of a port share one offset, and a bit in that port's control register chooses which of the two that offset reaches.

Each port has two handshake lines. Line 1 is always an input, and its selected edge raises an interrupt flag. Line 2 has several modes. It can be a second edge-flagged input, or an output held at a level the processor programs. On port A only, it can also be a read strobe: the line drops after the processor reads the data register, and it rises again either on the next active edge of line 1 or after one clock. Each port has an interrupt request output. A read of a port's data register clears that port's flags. The pins come out as separate in, out and output-enable vectors, so the pads can sit outside the block.

Top module: `pio_adapter`

## Requirements
- R1: The register offset `addr` reaches port A data or direction at 0, port A control at 1, port B data or direction at 2, and port B control at 3. A control read returns {flag1, flag2, bits 5:0 as last written}. `rdata` is zero when no read is active.
- R2: Control bit 2 selects what offsets 0 and 2 reach. A value of 0 selects the direction register and a value of 1 selects the data register, for both reads and writes.
- R3: A direction bit of 1 sets the matching `*_pin_oe` bit, and `*_pin_out` always shows the data latch. A data register read returns the latch value on output pins and the live `*_pin_in` value on input pins.
- R4: After reset, every register reads zero, all output enables are low, and both interrupt requests and both line 2 enables are low.
- R5: Control bit 1 picks the active edge of line 1 (0 falling, 1 rising). That edge sets flag bit 7 whatever the state of the enable bit 0. The flag is visible on the third rising clock edge after the pin changes.
- R6: When bit 5 is 0, line 2 is an input. Bit 4 then picks its active edge (0 falling, 1 rising), and that edge sets flag bit 6 with the same latency as R5. When bit 5 is 1, no line 2 edge sets the flag.
- R7: A read of a port's data register (bit 2 = 1) clears both flags of that port on that clock edge. An active edge detected on the same edge keeps its flag set. A direction register read clears nothing.
- R8: Processor writes to control bits 7 and 6 have no effect.
- R9: A port's `*_irq` is high exactly when (flag1 and bit 0) or (flag2 and bit 3 and bit 5 = 0).
- R10: With bits 5:4 = 11, line 2 is driven (`*_ctl2_oe` = 1) at the level of bit 3, on both ports.
- R11: On port A, bits 5:3 = 100 make line 2 a driven read strobe. A control write into this mode sets it high. It goes low on the clock edge of a data register read and returns high on the clock edge that detects the next active line 1 edge.
- R12: On port A, bits 5:3 = 101 make the strobe low for exactly one clock after a data register read.
- R13: On port B, bits 5:4 = 10 drive line 2 high and a data register read produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Bus select for this block |
| rd | input | 1 | Read cycle, qualified by cs |
| wr | input | 1 | Write cycle, qualified by cs |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational during a read |
| a_pin_in | input | 8 | Port A pin levels |
| a_pin_out | output | 8 | Port A output latch |
| a_pin_oe | output | 8 | Port A per-pin output enable |
| a_ctl1 | input | 1 | Port A handshake line 1 |
| a_ctl2_in | input | 1 | Port A handshake line 2 pin level |
| a_ctl2_out | output | 1 | Port A handshake line 2 drive value |
| a_ctl2_oe | output | 1 | Port A handshake line 2 output enable |
| a_irq | output | 1 | Port A interrupt request, active high |
| b_pin_in | input | 8 | Port B pin levels |
| b_pin_out | output | 8 | Port B output latch |
| b_pin_oe | output | 8 | Port B per-pin output enable |
| b_ctl1 | input | 1 | Port B handshake line 1 |
| b_ctl2_in | input | 1 | Port B handshake line 2 pin level |
| b_ctl2_out | output | 1 | Port B handshake line 2 drive value |
| b_ctl2_oe | output | 1 | Port B handshake line 2 output enable |
| b_irq | output | 1 | Port B interrupt request, active high |

## Verification
Register writes and read side effects take effect on the clock edge of the bus cycle, so both flag clearing and the strobe dropping are checked at the falling clock edge right after that cycle. A handshake line change passes two synchroniser stages and the flag register. The bench changes the pin at a falling edge, confirms that the flag and interrupt are still low two falling edges later, and confirms they are high at the third. The one-clock strobe is sampled at both falling edges around its single low cycle, and every read returns data sampled inside the read cycle, since `rdata` is combinational.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // control register bit positions
  localparam int CB_IE1   = 0;  // line 1 interrupt enable
  localparam int CB_EDGE1 = 1;  // line 1 active edge, 1 = rising
  localparam int CB_SEL   = 2;  // 1 = data register, 0 = direction register
  localparam int CB_IE2   = 3;  // line 2 irq enable / output level / pulse select
  localparam int CB_EDGE2 = 4;  // line 2 edge when input, level mode when output
  localparam int CB_DIR2  = 5;  // line 2 is output
  localparam int CB_FLAG2 = 6;
  localparam int CB_FLAG1 = 7;
  localparam int CTRL_RW_W = CB_DIR2 + 1;

  // offset layout: bit 1 picks the port, bit 0 picks the control register
  localparam int OFS_PORT_BIT = 1;
  localparam int OFS_CTRL_BIT = 0;
  localparam int NPORTS = 2;

  typedef enum logic [1:0] {
    L2_INPUT  = 2'b00,
    L2_STROBE = 2'b10,
    L2_LEVEL  = 2'b11
  } l2_mode_e;

  function automatic l2_mode_e l2_mode(input logic dir2, input logic edge2);
    if (!dir2)      return L2_INPUT;
    else if (edge2) return L2_LEVEL;
    else            return L2_STROBE;
  endfunction
endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;
  logic [LAST:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // sh_q[LAST-1] is the synchronised level, sh_q[LAST] its previous value
  assign rise = sh_q[LAST-1] & ~sh_q[LAST];
  assign fall = ~sh_q[LAST-1] & sh_q[LAST];
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit STROBE_EN   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_data,
  input  logic          sel_ctrl,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  input  logic          c1_pin,
  input  logic          c2_pin,
  output logic [DW-1:0] data_rdata,
  output logic [DW-1:0] ctrl_rdata,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  output logic          c2_out,
  output logic          c2_oe,
  output logic          irq
);
  logic [DW-1:0]        ddr_q, ddr_d;
  logic [DW-1:0]        odr_q, odr_d;
  logic [CTRL_RW_W-1:0] ctrl_q, ctrl_d;
  logic                 f1_q, f1_d;
  logic                 f2_q, f2_d;
  logic                 stb_q, stb_d;

  logic wr_ddr, wr_odr, wr_ctl, rd_pdr;
  logic c1_rise, c1_fall, c2_rise, c2_fall;
  logic edge1, edge2;
  l2_mode_e mode;

  pio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync1 (
    .clk(clk), .rst_n(rst_n), .pin(c1_pin), .rise(c1_rise), .fall(c1_fall)
  );
  pio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync2 (
    .clk(clk), .rst_n(rst_n), .pin(c2_pin), .rise(c2_rise), .fall(c2_fall)
  );

  // access decode
  assign wr_ddr = wr & sel_data & ~ctrl_q[CB_SEL];
  assign wr_odr = wr & sel_data &  ctrl_q[CB_SEL];
  assign wr_ctl = wr & sel_ctrl;
  assign rd_pdr = rd & sel_data &  ctrl_q[CB_SEL];

  assign mode  = l2_mode(ctrl_q[CB_DIR2], ctrl_q[CB_EDGE2]);
  assign edge1 = ctrl_q[CB_EDGE1] ? c1_rise : c1_fall;
  assign edge2 = (mode == L2_INPUT) & (ctrl_q[CB_EDGE2] ? c2_rise : c2_fall);

  // next state: registers with explicit enables
  always_comb begin
    ddr_d  = ddr_q;
    odr_d  = odr_q;
    ctrl_d = ctrl_q;
    if (wr_ddr) ddr_d  = wdata;
    if (wr_odr) odr_d  = wdata;
    if (wr_ctl) ctrl_d = wdata[CTRL_RW_W-1:0];
  end

  // flags: a fresh edge wins over the clearing read
  always_comb begin
    f1_d = edge1 | (f1_q & ~rd_pdr);
    f2_d = edge2 | (f2_q & ~rd_pdr);
  end

  generate
    if (STROBE_EN) begin : g_strobe
      always_comb begin
        stb_d = stb_q;
        if (wr_ctl)                      stb_d = 1'b1;
        else if (mode != L2_STROBE)      stb_d = 1'b1;
        else if (rd_pdr)                 stb_d = 1'b0;
        else if (ctrl_q[CB_IE2] | edge1) stb_d = 1'b1;
      end

      p_strobe_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == L2_STROBE && rd_pdr && !wr_ctl) |=> !c2_out);

      p_pulse_restore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == L2_STROBE && ctrl_q[CB_IE2] && !stb_q && !rd_pdr && !wr_ctl) |=> stb_q);
    end else begin : g_no_strobe
      always_comb stb_d = 1'b1;

      p_no_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == L2_STROBE && rd_pdr && !wr_ctl) |=> c2_out);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ddr_q  <= '0;
      odr_q  <= '0;
      ctrl_q <= '0;
      f1_q   <= 1'b0;
      f2_q   <= 1'b0;
      stb_q  <= 1'b1;
    end else begin
      ddr_q  <= ddr_d;
      odr_q  <= odr_d;
      ctrl_q <= ctrl_d;
      f1_q   <= f1_d;
      f2_q   <= f2_d;
      stb_q  <= stb_d;
    end
  end

  // outputs
  assign pin_out    = odr_q;
  assign pin_oe     = ddr_q;
  assign c2_oe      = ctrl_q[CB_DIR2];
  assign c2_out     = (mode == L2_LEVEL) ? ctrl_q[CB_IE2] : stb_q;
  assign irq        = (f1_q & ctrl_q[CB_IE1]) |
                      (f2_q & ctrl_q[CB_IE2] & ~ctrl_q[CB_DIR2]);
  assign data_rdata = ctrl_q[CB_SEL] ? ((odr_q & ddr_q) | (pin_in & ~ddr_q)) : ddr_q;
  assign ctrl_rdata = DW'({f1_q, f2_q, ctrl_q});

  // assertions
  p_flag1_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge1 |=> f1_q);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pdr && !edge1) |=> !f1_q);

  p_flag2_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_DIR2] && !f2_q) |=> !f2_q);

  p_flags_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !f1_q && !edge1) |=> !f1_q);
endmodule

// File: rtl/pio_adapter.sv
module pio_adapter
  import pio_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] a_pin_in,
  output logic [DW-1:0] a_pin_out,
  output logic [DW-1:0] a_pin_oe,
  input  logic          a_ctl1,
  input  logic          a_ctl2_in,
  output logic          a_ctl2_out,
  output logic          a_ctl2_oe,
  output logic          a_irq,
  input  logic [DW-1:0] b_pin_in,
  output logic [DW-1:0] b_pin_out,
  output logic [DW-1:0] b_pin_oe,
  input  logic          b_ctl1,
  input  logic          b_ctl2_in,
  output logic          b_ctl2_out,
  output logic          b_ctl2_oe,
  output logic          b_irq
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic [DW-1:0] pin_in_v  [NPORTS];
  logic [DW-1:0] pin_out_v [NPORTS];
  logic [DW-1:0] pin_oe_v  [NPORTS];
  logic [DW-1:0] data_rd_v [NPORTS];
  logic [DW-1:0] ctrl_rd_v [NPORTS];
  logic [NPORTS-1:0] c1_v, c2_in_v, c2_out_v, c2_oe_v, irq_v;
  logic [NPORTS-1:0] sel_data, sel_ctrl;

  assign pin_in_v[0] = a_pin_in;
  assign pin_in_v[1] = b_pin_in;
  assign c1_v        = {b_ctl1, a_ctl1};
  assign c2_in_v     = {b_ctl2_in, a_ctl2_in};

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      assign sel_data[p] = cs & (addr[OFS_PORT_BIT] == 1'(p)) & ~addr[OFS_CTRL_BIT];
      assign sel_ctrl[p] = cs & (addr[OFS_PORT_BIT] == 1'(p)) &  addr[OFS_CTRL_BIT];

      pio_port #(
        .DW(DW),
        .SYNC_STAGES(SYNC_STAGES),
        .STROBE_EN(p == 0)
      ) u_port (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .sel_data   (sel_data[p]),
        .sel_ctrl   (sel_ctrl[p]),
        .rd         (rd),
        .wr         (wr),
        .wdata      (wdata),
        .pin_in     (pin_in_v[p]),
        .c1_pin     (c1_v[p]),
        .c2_pin     (c2_in_v[p]),
        .data_rdata (data_rd_v[p]),
        .ctrl_rdata (ctrl_rd_v[p]),
        .pin_out    (pin_out_v[p]),
        .pin_oe     (pin_oe_v[p]),
        .c2_out     (c2_out_v[p]),
        .c2_oe      (c2_oe_v[p]),
        .irq        (irq_v[p])
      );
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      if (addr[OFS_CTRL_BIT]) rdata = ctrl_rd_v[addr[OFS_PORT_BIT]];
      else                    rdata = data_rd_v[addr[OFS_PORT_BIT]];
    end
  end

  assign a_pin_out  = pin_out_v[0];
  assign a_pin_oe   = pin_oe_v[0];
  assign a_ctl2_out = c2_out_v[0];
  assign a_ctl2_oe  = c2_oe_v[0];
  assign a_irq      = irq_v[0];
  assign b_pin_out  = pin_out_v[1];
  assign b_pin_oe   = pin_oe_v[1];
  assign b_ctl2_out = c2_out_v[1];
  assign b_ctl2_oe  = c2_oe_v[1];
  assign b_irq      = irq_v[1];

  p_idle_rdata_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(cs && rd) |-> (rdata == '0));
endmodule

// File: tb/pio_adapter_bench.sv
`timescale 1ns/1ps
module pio_adapter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, rd, wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] a_pin_in, a_pin_out, a_pin_oe;
  logic [7:0] b_pin_in, b_pin_out, b_pin_oe;
  logic       a_ctl1, a_ctl2_in, a_ctl2_out, a_ctl2_oe, a_irq;
  logic       b_ctl1, b_ctl2_in, b_ctl2_out, b_ctl2_oe, b_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pio_adapter u_pio_adapter (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe),
    .a_ctl1(a_ctl1), .a_ctl2_in(a_ctl2_in), .a_ctl2_out(a_ctl2_out),
    .a_ctl2_oe(a_ctl2_oe), .a_irq(a_irq),
    .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
    .b_ctl1(b_ctl1), .b_ctl2_in(b_ctl2_in), .b_ctl2_out(b_ctl2_out),
    .b_ctl2_oe(b_ctl2_oe), .b_irq(b_irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      bus_read(2'(i), v);
      chk(v, 8'h00, "R4 register after reset");
    end
    chk(a_pin_oe, 8'h00, "R4 port A oe");
    chk(b_pin_oe, 8'h00, "R4 port B oe");
    chk({6'd0, a_irq, b_irq}, 8'h00, "R4 irq");
    chk({6'd0, a_ctl2_oe, b_ctl2_oe}, 8'h00, "R4 line2 oe");
    #1 chk(rdata, 8'h00, "R1 idle rdata");
  endtask

  task automatic t_registers();
    logic [7:0] v;
    bus_write(2'd0, 8'h0F);
    chk(a_pin_oe, 8'h0F, "R2 direction write via offset 0");
    bus_write(2'd1, 8'h04);
    bus_write(2'd0, 8'hA5);
    chk(a_pin_out, 8'hA5, "R3 port A latch");
    chk(a_pin_oe, 8'h0F, "R2 data write leaves direction");
    a_pin_in = 8'h3C;
    bus_read(2'd0, v);
    chk(v, 8'h35, "R3 mixed read");
    bus_read(2'd1, v);
    chk(v, 8'h04, "R1 control A read");
    bus_write(2'd2, 8'hFF);
    chk(b_pin_oe, 8'hFF, "R1 port B direction at offset 2");
    chk(a_pin_oe, 8'h0F, "R1 port A untouched");
    bus_write(2'd3, 8'h04);
    bus_write(2'd2, 8'h5A);
    chk(b_pin_out, 8'h5A, "R3 port B latch");
    bus_read(2'd2, v);
    chk(v, 8'h5A, "R3 port B output read");
    bus_read(2'd3, v);
    chk(v, 8'h04, "R1 control B read");
  endtask

  task automatic t_line1();
    logic [7:0] v;
    bus_write(2'd1, 8'h07);
    a_ctl1 = 1'b1;
    wait_n(2);
    chk({7'd0, a_irq}, 8'h00, "R5 flag not yet set");
    wait_n(1);
    chk({7'd0, a_irq}, 8'h01, "R5 R9 rising edge irq");
    bus_read(2'd1, v);
    chk(v, 8'h87, "R5 flag bit 7");
    bus_write(2'd1, 8'h47);
    bus_read(2'd1, v);
    chk(v, 8'h87, "R8 bit 6 write ignored");
    bus_write(2'd1, 8'h07);
    bus_read(2'd1, v);
    chk(v, 8'h87, "R8 bit 7 write ignored");
    bus_read(2'd0, v);
    chk({7'd0, a_irq}, 8'h00, "R7 irq after data read");
    bus_read(2'd1, v);
    chk(v, 8'h07, "R7 flag cleared");
    bus_write(2'd1, 8'h05);
    a_ctl1 = 1'b0;
    wait_n(3);
    chk({7'd0, a_irq}, 8'h01, "R5 falling edge irq");
    bus_write(2'd1, 8'h04);
    chk({7'd0, a_irq}, 8'h00, "R9 irq masked");
    bus_read(2'd1, v);
    chk(v, 8'h84, "R9 flag kept while masked");
    bus_read(2'd0, v);
  endtask

  task automatic t_ddr_read_keeps();
    logic [7:0] v;
    bus_write(2'd1, 8'h06);
    a_ctl1 = 1'b1;
    wait_n(3);
    chk({7'd0, a_irq}, 8'h00, "R9 disabled irq stays low");
    bus_write(2'd1, 8'h02);
    bus_read(2'd0, v);
    chk(v, 8'h0F, "R2 offset 0 reads direction");
    bus_read(2'd1, v);
    chk(v, 8'h82, "R5 R7 flag set while disabled, kept on direction read");
    bus_write(2'd1, 8'h06);
    bus_read(2'd0, v);
    bus_read(2'd1, v);
    chk(v, 8'h06, "R7 cleared by data read");
  endtask

  task automatic t_line2();
    logic [7:0] v;
    bus_write(2'd1, 8'h1C);
    a_ctl2_in = 1'b1;
    wait_n(2);
    chk({7'd0, a_irq}, 8'h00, "R6 line 2 flag not yet set");
    wait_n(1);
    chk({7'd0, a_irq}, 8'h01, "R6 R9 line 2 irq");
    bus_read(2'd1, v);
    chk(v, 8'h5C, "R6 flag bit 6");
    bus_read(2'd0, v);
    bus_read(2'd1, v);
    chk(v, 8'h1C, "R7 line 2 flag cleared");
    bus_write(2'd1, 8'h3C);
    chk({6'd0, a_ctl2_oe, a_ctl2_out}, 8'h03, "R10 level high");
    a_ctl2_in = 1'b0;
    wait_n(3);
    a_ctl2_in = 1'b1;
    wait_n(4);
    bus_read(2'd1, v);
    chk(v, 8'h3C, "R6 no flag when output");
    chk({7'd0, a_irq}, 8'h00, "R9 no line 2 irq when output");
    bus_write(2'd1, 8'h34);
    chk({6'd0, a_ctl2_oe, a_ctl2_out}, 8'h02, "R10 level low");
  endtask

  task automatic t_strobe_edge();
    logic [7:0] v;
    bus_write(2'd1, 8'h26);
    chk({6'd0, a_ctl2_oe, a_ctl2_out}, 8'h03, "R11 strobe idle high");
    a_ctl1 = 1'b0;
    wait_n(4);
    chk({7'd0, a_ctl2_out}, 8'h01, "R11 inactive edge no effect");
    bus_read(2'd0, v);
    chk({7'd0, a_ctl2_out}, 8'h00, "R11 low after read");
    wait_n(3);
    chk({7'd0, a_ctl2_out}, 8'h00, "R11 held low");
    a_ctl1 = 1'b1;
    wait_n(2);
    chk({7'd0, a_ctl2_out}, 8'h00, "R11 still low before edge detect");
    wait_n(1);
    chk({7'd0, a_ctl2_out}, 8'h01, "R11 restored by line 1");
  endtask

  task automatic t_strobe_pulse();
    logic [7:0] v;
    bus_write(2'd1, 8'h2C);
    chk({7'd0, a_ctl2_out}, 8'h01, "R12 idle high");
    bus_read(2'd0, v);
    chk({7'd0, a_ctl2_out}, 8'h00, "R12 pulse low");
    wait_n(1);
    chk({7'd0, a_ctl2_out}, 8'h01, "R12 high after one clock");
    wait_n(1);
    chk({7'd0, a_ctl2_out}, 8'h01, "R12 stays high");
  endtask

  task automatic t_port_b_line2();
    logic [7:0] v;
    bus_write(2'd3, 8'h26);
    chk({6'd0, b_ctl2_oe, b_ctl2_out}, 8'h03, "R13 port B driven high");
    bus_read(2'd2, v);
    chk({7'd0, b_ctl2_out}, 8'h01, "R13 no strobe after read");
    wait_n(1);
    chk({7'd0, b_ctl2_out}, 8'h01, "R13 still high");
    bus_write(2'd3, 8'h30);
    chk({6'd0, b_ctl2_oe, b_ctl2_out}, 8'h02, "R10 port B level low");
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = 2'd0; wdata = 8'h00;
    a_pin_in = 8'h00; b_pin_in = 8'h00;
    a_ctl1 = 1'b0; a_ctl2_in = 1'b0; b_ctl1 = 1'b0; b_ctl2_in = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    t_reset_state();
    t_registers();
    t_line1();
    t_ddr_read_keeps();
    t_line2();
    t_strobe_edge();
    t_strobe_pulse();
    t_port_b_line2();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule